// File: doc/BRIEF.md
# Consecutive-Zero Auto-Mute Detector

This block watches the sample stream feeding a bank of six audio DAC channels and raises a single global mute once every channel has carried silence for a long unbroken run of frames. A channel sample counts as silent when it is all zeros or all ones (the value -1). The global mute is meant to be ORed into every channel's own mute.

A frame strobe marks each frame. The six signed samples are presented as one packed bus while the strobe is high. A run counter advances on each strobed frame in which all six channels are silent. It clears on any strobed frame that has a non-silent channel. The auto-mute fires at a fixed run length of 768 frames. An enable input switches the auto-mute function off. Separately, a clock-loss error flag from the clock multiplier forces the mute high at once, whatever the enable says.

Top module: `zmute_detector`

## Requirements
- R1: While reset is held, and after its release until a full silent run has been seen, `mute_all` is low when `clk_err` is low.
- R2: Channel c occupies bits [c*24 +: 24] of `smp_bus`. A channel counts as silent when its 24 bits are all 0 or all 1. A strobed frame counts toward the run only when all six channels are silent, in any mix of the two codes.
- R3: With `am_en` high, `mute_all` rises in the cycle after the clock edge that samples the 768th consecutive all-silent strobed frame, and not before.
- R4: Cycles with `frame_stb` low neither advance nor clear the run, whatever `smp_bus` carries.
- R5: A strobed frame with any single non-silent channel drops the auto-mute in the cycle after that edge. The run then restarts from zero.
- R6: Once reached, the auto-mute stays high through any further silent frames, with the run count saturating at 768.
- R7: While `am_en` is low, the auto-mute is low and the run is held at zero. After re-enabling, a full run of 768 frames is needed again.
- R8: `clk_err` high drives `mute_all` high in the same cycle, combinationally, independent of `am_en` and of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-cycle frame strobe |
| smp_bus | input | 144 | Six 24-bit signed samples, channel c at bits [c*24 +: 24] |
| am_en | input | 1 | Auto-mute enable |
| clk_err | input | 1 | Clock multiplier error flag |
| mute_all | output | 1 | Global mute |

## Verification
The run state is registered, so the effect of a strobed frame on `mute_all` becomes visible one clock edge after the frame is sampled. The `clk_err` path has no register and takes effect in the same cycle. The bench drives inputs on the falling edge and checks `mute_all` shortly after, against a bench model of the run count that is updated at each rising edge. Every comparison therefore sees exactly the state produced by the previous edge and the inputs of the current cycle. Directed cases hit run lengths 767 and 768, saturation, single-channel release, strobe gaps, enable toggling and clock error. Seeded random frames then mix silent and noisy channels.

// File: rtl/zmute_pkg.sv
package zmute_pkg;
  localparam int unsigned DEF_NCH    = 6;
  localparam int unsigned DEF_SW     = 24;
  localparam int unsigned DEF_THRESH = 768;
endpackage

// File: rtl/zmute_rst_sync.sv
module zmute_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/zmute_silence.sv
module zmute_silence #(
  parameter int unsigned NCH = zmute_pkg::DEF_NCH,
  parameter int unsigned SW  = zmute_pkg::DEF_SW
) (
  input  logic [NCH*SW-1:0] smp_bus,
  output logic [NCH-1:0]    ch_quiet,
  output logic              all_quiet
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] smp;
    assign smp         = smp_bus[c*SW +: SW];
    // R2: zero code or minus-one code
    assign ch_quiet[c] = (~|smp) | (&smp);
  end

  assign all_quiet = &ch_quiet;
endmodule

// File: rtl/zmute_run_cnt.sv
module zmute_run_cnt #(
  parameter int unsigned THRESH = zmute_pkg::DEF_THRESH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic all_quiet,
  input  logic am_en,
  output logic armed
);
  localparam int unsigned CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] THR = CW'(THRESH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!am_en) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (frame_stb) begin
      cnt_en = 1'b1;
      if (!all_quiet)       cnt_d = '0;
      else if (cnt_q != THR) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign armed = (cnt_q == THR);

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= THR);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !all_quiet) |=> (cnt_q == '0));
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (am_en && frame_stb && all_quiet && cnt_q != THR) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r4_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (am_en && !frame_stb) |=> $stable(cnt_q));
  a_r7_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !am_en |=> !armed);
endmodule

// File: rtl/zmute_detector.sv
module zmute_detector #(
  parameter int unsigned NCH    = zmute_pkg::DEF_NCH,
  parameter int unsigned SW     = zmute_pkg::DEF_SW,
  parameter int unsigned THRESH = zmute_pkg::DEF_THRESH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [NCH*SW-1:0] smp_bus,
  input  logic              am_en,
  input  logic              clk_err,
  output logic              mute_all
);
  logic           rst_sync_n;
  logic [NCH-1:0] ch_quiet;
  logic           all_quiet;
  logic           armed;

  zmute_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  zmute_silence #(.NCH(NCH), .SW(SW)) u_sil (
    .smp_bus   (smp_bus),
    .ch_quiet  (ch_quiet),
    .all_quiet (all_quiet)
  );

  zmute_run_cnt #(.THRESH(THRESH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_stb (frame_stb),
    .all_quiet (all_quiet),
    .am_en     (am_en),
    .armed     (armed)
  );

  assign mute_all = clk_err | (am_en & armed);

  a_r8_clk_err_mute: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clk_err |-> mute_all);
  a_r5_noisy_unmute: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_stb && !all_quiet && !clk_err) |=> (!mute_all || clk_err));
  a_r2_noisy_chan: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ch_quiet != '1) |-> !all_quiet);
endmodule

// File: tb/zmute_detector_test.sv
module zmute_detector_test;
  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int THR = 768;

  logic              clk;
  logic              rst_n;
  logic              frame_stb;
  logic [NCH*SW-1:0] smp_bus;
  logic              am_en;
  logic              clk_err;
  logic              mute_all;

  int total;
  int bad;
  int mcnt;
  int cycles;
  bit done;

  zmute_detector uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .smp_bus   (smp_bus),
    .am_en     (am_en),
    .clk_err   (clk_err),
    .mute_all  (mute_all)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [SW-1:0] noisy_word();
    logic [SW-1:0] w = SW'($urandom);
    if (w == '0 || w == '1) w = SW'(1);
    return w;
  endfunction

  // silent frame with a random mix of zero and minus-one codes
  function automatic logic [NCH*SW-1:0] quiet_frame();
    logic [NCH*SW-1:0] f;
    for (int c = 0; c < NCH; c++) f[c*SW +: SW] = ($urandom % 2) ? '1 : '0;
    return f;
  endfunction

  function automatic logic exp_mute(int cnt, logic en, logic err);
    return err | (en & (cnt == THR));
  endfunction

  function automatic int next_cnt(int cnt, logic stb, logic [NCH*SW-1:0] f, logic en);
    logic q = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (f[c*SW +: SW] != '0 && f[c*SW +: SW] != '1) q = 1'b0;
    if (!en) return 0;
    if (!stb) return cnt;
    if (!q) return 0;
    return (cnt < THR) ? cnt + 1 : cnt;
  endfunction

  task automatic check(string tag);
    logic e = exp_mute(mcnt, am_en, clk_err);
    total++;
    if (mute_all !== e) begin
      bad++;
      $display("FAIL %s: mute_all=%0b expected=%0b (run=%0d)", tag, mute_all, e, mcnt);
    end
  endtask

  // inputs driven after the falling edge, checked 1 ns later, model advanced at rising edge
  task automatic step(logic stb, logic [NCH*SW-1:0] f, logic en, logic err, string tag, bit chk);
    frame_stb = stb; smp_bus = f; am_en = en; clk_err = err;
    #1;
    if (chk) check(tag);
    @(posedge clk);
    mcnt = next_cnt(mcnt, stb, f, en);
    @(negedge clk);
  endtask

  task automatic quiet_run(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, quiet_frame(), 1'b1, 1'b0, tag, 1'b0);
  endtask

  initial begin
    cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [NCH*SW-1:0] f;
    void'($urandom(32'd4711));
    total = 0; bad = 0; mcnt = 0; done = 1'b0;
    rst_n = 1'b0; frame_stb = 1'b0; smp_bus = '0; am_en = 1'b1; clk_err = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, '0, 1'b1, 1'b0, "R1 after reset", 1'b1);

    // R3: 767 silent frames, not yet muted; 768th mutes
    quiet_run(THR - 1, "R3 run");
    step(1'b0, '0, 1'b1, 1'b0, "R3 at 767", 1'b1);
    step(1'b1, quiet_frame(), 1'b1, 1'b0, "R3 768th frame", 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, "R3 after 768", 1'b1);
    // R6 saturation
    quiet_run(50, "R6 run");
    step(1'b0, '0, 1'b1, 1'b0, "R6 saturated", 1'b1);
    // R4 gaps with noise on the bus while strobe low
    for (int i = 0; i < 5; i++) step(1'b0, {NCH{noisy_word()}}, 1'b1, 1'b0, "R4 gap noise", 1'b1);
    // R5 single non-silent channel (channel 5)
    f = quiet_frame(); f[5*SW +: SW] = noisy_word();
    step(1'b1, f, 1'b1, 1'b0, "R5 noisy frame", 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, "R5 released", 1'b1);
    // R2 mixed codes: all zero then all minus one alternating
    for (int i = 0; i < THR; i++) step(1'b1, (i % 2) ? '1 : '0, 1'b1, 1'b0, "R2 mix", 1'b0);
    step(1'b0, '0, 1'b1, 1'b0, "R2 mixed run mutes", 1'b1);
    // R8 with enable low; R7 enable low clears
    step(1'b0, '0, 1'b0, 1'b1, "R8 err en low", 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, "R7 disabled low", 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, "R7 re-enable no mute", 1'b1);
    quiet_run(THR - 1, "R7 run");
    step(1'b0, '0, 1'b1, 1'b0, "R7 short of full run", 1'b1);
    // R7 long silence while disabled
    for (int i = 0; i < THR + 10; i++) step(1'b1, '0, 1'b0, 1'b0, "R7 off", 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, "R7 off after long silence", 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, "R7 on after long silence", 1'b1);
    // R8 with silent idle
    step(1'b0, '0, 1'b1, 1'b1, "R8 err instant", 1'b1);
    step(1'b0, '0, 1'b1, 1'b0, "R8 err gone", 1'b1);

    // random phase
    for (int i = 0; i < 12000; i++) begin
      logic stb = ($urandom % 4) != 0;
      logic en  = ($urandom % 400) != 0;
      logic err = ($urandom % 300) == 0;
      f = quiet_frame();
      if (($urandom % 1500) == 0) f[($urandom % NCH)*SW +: SW] = noisy_word();
      step(stb, f, en, err, "R3 R5 R7 R8 random", 1'b1);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule